// File: doc/BRIEF.md
# Multi-Channel Sticky Status Register Bank

This block collects live alarm and status levels from eight identical line channels and turns their transitions into sticky flags that a host can poll. Every status bit has a fixed edge rule chosen at build time. A rising-only bit records a change from 0 to 1. An either-edge bit records any change of level. Once set, a flag stays set until the host reads it back, so a short pulse that falls again before software looks is not lost.

The host reaches the bank over a simple synchronous bus with separate read and write strobes. Bits 11 to 8 of the address select the channel and the low byte selects the register inside that channel. Each channel has three registers: the latched flags, an interrupt status view of those flags, and an interrupt mask. Reading either the latched flags or the interrupt status view clears all of that channel's flags. The interrupt status view shows the flags ANDed with the mask. Each channel also drives an interrupt line that is high while any unmasked flag is set.

Top module: `stat_latch_bank`

## Requirements
- R1: Address bits 11..8 select channel 0..7. An access with channel 8..15 returns zero data, writes nothing and clears nothing.
- R2: A rising-only bit sets its flag when the live input goes from 0 to 1 and never on a 1-to-0 change. With the defaults, the even bit positions 0, 2, 4 and 6 are rising-only.
- R3: An either-edge bit sets its flag on both a 0-to-1 and a 1-to-0 change of the live input. With the defaults, the odd positions 1, 3, 5 and 7 are either-edge.
- R4: A set flag stays set, whatever the live input does afterwards, until a clearing read.
- R5: A read at low-byte offset 0x10 returns the channel's flags in bits 7..0, with bits 15..8 at zero. The data is valid in the cycle after the read strobe, and the read clears all flags of that channel.
- R6: A read at offset 0x14 returns the channel's flags ANDed with its mask, with the same timing. It also clears all flags of that channel, masked or not.
- R7: If a qualifying edge arrives in the same cycle as a clearing read, the read returns the earlier flag value and the new flag is set afterwards.
- R8: After a synchronous reset, all flags, masks, read data and interrupt lines are zero. A live input that is already high when reset ends produces no flag.
- R9: A write at offset 0x18 loads the channel's 8-bit mask, and a read there returns it without clearing anything. Interrupt line c is high exactly when channel c has a flag set whose mask bit is 1.
- R10: A read at any other offset returns zero and leaves every flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| live_stat | input | 64 | Live status levels, channel c in bits 8c+7..8c |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 12 | Channel in bits 11..8, register offset in bits 7..0 |
| bus_wdata | input | 16 | Write data, mask in bits 7..0 |
| bus_rdata | output | 16 | Read data, valid the cycle after bus_rd |
| irq | output | 8 | Per-channel interrupt, one bit per channel |

## Verification
The hardest case to reach is a clearing read that lands in the same clock cycle as a fresh edge on the channel being read (R7). The stimulus reaches it by setting the live input and raising the read strobe on the same falling clock edge. Two reads then follow: the first must return only the older flag, and the second must return the new one. Aliasing is also tested. The bench writes and reads channel numbers 8 and up, whose low three bits name a real channel, and then reads that real channel to check its flags and mask are untouched.

// File: rtl/stat_bank_pkg.sv
package stat_bank_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 16;
    localparam int CH_LSB = 8;
    localparam int CH_W   = 4;
    localparam int OFS_W  = 8;

    localparam logic [OFS_W-1:0] OFS_FLAGS = 8'h10;
    localparam logic [OFS_W-1:0] OFS_ISTAT = 8'h14;
    localparam logic [OFS_W-1:0] OFS_MASK  = 8'h18;

    typedef enum logic [1:0] {
        REG_NONE  = 2'd0,
        REG_FLAGS = 2'd1,
        REG_ISTAT = 2'd2,
        REG_MASK  = 2'd3
    } reg_kind_e;

    typedef struct packed {
        logic            hit;
        logic [CH_W-1:0] ch;
        reg_kind_e       kind;
    } bus_dec_t;

    function automatic reg_kind_e kind_of(input logic [OFS_W-1:0] ofs);
        reg_kind_e k;
        case (ofs)
            OFS_FLAGS: k = REG_FLAGS;
            OFS_ISTAT: k = REG_ISTAT;
            OFS_MASK:  k = REG_MASK;
            default:   k = REG_NONE;
        endcase
        return k;
    endfunction

    function automatic logic is_clearing(input reg_kind_e k);
        return (k == REG_FLAGS) || (k == REG_ISTAT);
    endfunction

endpackage

// File: rtl/sbk_addr_decode.sv
module sbk_addr_decode
    import stat_bank_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output bus_dec_t          dec,
    output logic [NCH-1:0]    ch_sel
);
    logic [CH_W-1:0] ch_idx;
    reg_kind_e       kind;
    logic            ch_ok;

    assign ch_idx = addr[CH_LSB +: CH_W];
    assign kind   = kind_of(addr[OFS_W-1:0]);
    assign ch_ok  = (int'(ch_idx) < NCH);

    always_comb begin
        dec.hit  = ch_ok && (kind != REG_NONE);
        dec.ch   = ch_idx;
        dec.kind = kind;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_sel
        assign ch_sel[c] = dec.hit && (int'(ch_idx) == c);
    end

    always_comb begin
        assert ($onehot0(ch_sel)) else $error("assert_sel_onehot_R1 failed");
    end
endmodule

// File: rtl/sbk_chan_latch.sv
module sbk_chan_latch
    import stat_bank_pkg::*;
#(
    parameter int               NBITS    = 8,
    parameter logic [NBITS-1:0] ANY_EDGE = 8'hAA
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NBITS-1:0] live,
    input  logic             sel,
    input  logic             rd,
    input  logic             wr,
    input  reg_kind_e        kind,
    input  logic [NBITS-1:0] wdata,
    output logic [NBITS-1:0] flags,
    output logic [NBITS-1:0] mask,
    output logic             irq
);
    logic [NBITS-1:0] prev;
    logic [NBITS-1:0] qual;
    logic             clr;
    logic             mask_we;

    // Tracks live during reset too, so a level held across reset is no edge.
    always_ff @(posedge clk) prev <= live;

    for (genvar b = 0; b < NBITS; b++) begin : g_rule
        if (ANY_EDGE[b]) begin : g_any
            assign qual[b] = live[b] ^ prev[b];
        end else begin : g_rise
            assign qual[b] = live[b] & ~prev[b];
        end
    end

    assign clr     = sel && rd && is_clearing(kind);
    assign mask_we = sel && wr && (kind == REG_MASK);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            flags <= (flags & ~{NBITS{clr}}) | qual;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '0;
        end else if (mask_we) begin
            mask <= wdata;
        end
    end

    assign irq = |(flags & mask);

    // An edge sets its flag even when a clearing read arrives with it.
    assert_edge_sets_R7: assert property (@(posedge clk) disable iff (rst)
        (qual != '0) |=> ((flags & $past(qual)) == $past(qual)));

    // A clearing read with no edge leaves all flags of the channel low.
    assert_read_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (clr && qual == '0) |=> (flags == '0));

    // Without a clearing read no flag drops.
    assert_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((flags & $past(flags)) == $past(flags)));

    // A flag only rises in response to its edge rule (R2, R3).
    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flags & ~$past(flags) & ~$past(qual)) == '0));

    assert_mask_load_R9: assert property (@(posedge clk) disable iff (rst)
        mask_we |=> (mask == $past(wdata)));
endmodule

// File: rtl/sbk_read_mux.sv
module sbk_read_mux
    import stat_bank_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int NBITS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rd,
    input  bus_dec_t             dec,
    input  logic [NCH*NBITS-1:0] flags_all,
    input  logic [NCH*NBITS-1:0] mask_all,
    output logic [DATA_W-1:0]    rdata
);
    localparam int PAD = DATA_W - NBITS;

    logic [NBITS-1:0] flags_ch;
    logic [NBITS-1:0] mask_ch;
    logic [NBITS-1:0] field;

    always_comb begin
        flags_ch = '0;
        mask_ch  = '0;
        for (int c = 0; c < NCH; c++) begin
            if (int'(dec.ch) == c) begin
                flags_ch = flags_all[c*NBITS +: NBITS];
                mask_ch  = mask_all[c*NBITS +: NBITS];
            end
        end
    end

    always_comb begin
        field = '0;
        if (dec.hit) begin
            case (dec.kind)
                REG_FLAGS: field = flags_ch;
                REG_ISTAT: field = flags_ch & mask_ch;
                REG_MASK:  field = mask_ch;
                default:   field = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd) begin
            rdata <= {{PAD{1'b0}}, field};
        end
    end

    assert_miss_reads_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (rd && !dec.hit) |=> (rdata == '0));

    assert_upper_zero_R5: assert property (@(posedge clk) disable iff (rst)
        $past(rd) |-> (rdata[DATA_W-1:NBITS] == '0));
endmodule

// File: rtl/stat_latch_bank.sv
module stat_latch_bank
    import stat_bank_pkg::*;
#(
    parameter int               NCH      = 8,
    parameter int               NBITS    = 8,
    parameter logic [NBITS-1:0] ANY_EDGE = 8'hAA
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NCH*NBITS-1:0]      live_stat,
    input  logic                      bus_rd,
    input  logic                      bus_wr,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    output logic [NCH-1:0]            irq
);
    localparam int TOTAL = NCH * NBITS;

    bus_dec_t         dec;
    logic [NCH-1:0]   ch_sel;
    logic [TOTAL-1:0] flags_all;
    logic [TOTAL-1:0] mask_all;

    sbk_addr_decode #(.NCH(NCH)) u_dec (
        .addr   (bus_addr),
        .dec    (dec),
        .ch_sel (ch_sel)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        sbk_chan_latch #(.NBITS(NBITS), .ANY_EDGE(ANY_EDGE)) u_lat (
            .clk   (clk),
            .rst   (rst),
            .live  (live_stat[c*NBITS +: NBITS]),
            .sel   (ch_sel[c]),
            .rd    (bus_rd),
            .wr    (bus_wr),
            .kind  (dec.kind),
            .wdata (bus_wdata[NBITS-1:0]),
            .flags (flags_all[c*NBITS +: NBITS]),
            .mask  (mask_all[c*NBITS +: NBITS]),
            .irq   (irq[c])
        );
    end

    sbk_read_mux #(.NCH(NCH), .NBITS(NBITS)) u_rmux (
        .clk       (clk),
        .rst       (rst),
        .rd        (bus_rd),
        .dec       (dec),
        .flags_all (flags_all),
        .mask_all  (mask_all),
        .rdata     (bus_rdata)
    );

    // A clearing read with steady inputs drops that channel's interrupt.
    assert_irq_drops_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && dec.hit && is_clearing(dec.kind) &&
         live_stat == $past(live_stat)) |=> (irq[dec.ch[2:0]] == 1'b0 || $past(dec.ch) >= NCH));
endmodule

// File: tb/sim_stat_latch_bank.sv
`timescale 1ns/1ps
module sim_stat_latch_bank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] live_stat = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic        rd_d = 1'b0;

    always #5 clk = ~clk;

    stat_latch_bank u0 (
        .clk(clk), .rst(rst), .live_stat(live_stat),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // Monitor: read data is due one cycle after the strobe.
    always @(posedge clk) rd_d <= bus_rd;
    always @(negedge clk) begin
        if (rd_d && exp_q.size() > 0) begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                errors++;
                $display("FAIL %s: rdata=%h expected=%h", t, bus_rdata, e);
            end
        end
    end

    task automatic rd_chk(input logic [11:0] a, input logic [15:0] e, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_live(input logic [11:0] a, input logic [15:0] e, input string tag,
                           input int ch, input logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        live_stat[ch*8 +: 8] = v;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr_reg(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic set_live(input int ch, input logic [7:0] v);
        @(negedge clk);
        live_stat[ch*8 +: 8] = v;
    endtask

    task automatic chk_irq(input logic [7:0] e, input string tag);
        @(negedge clk);
        checks++;
        if (irq !== e) begin
            errors++;
            $display("FAIL %s: irq=%h expected=%h", tag, irq, e);
        end
    endtask

    initial begin
        live_stat[7:0] = 8'hFF;
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R8: reset state, held-high live input gives no flag
        checks++;
        if (bus_rdata !== 16'h0 || irq !== 8'h0) begin
            errors++;
            $display("FAIL R8: rdata=%h irq=%h expected=0 0", bus_rdata, irq);
        end
        rd_chk(12'h010, 16'h0000, "R8 flags after reset");
        rd_chk(12'h018, 16'h0000, "R8 mask after reset");

        // R2/R3: falling all bits sets either-edge ones only
        set_live(0, 8'h00);
        rd_chk(12'h010, 16'h00AA, "R3 fall sets odd bits, R2 not even");
        rd_chk(12'h010, 16'h0000, "R5 read cleared flags");
        set_live(0, 8'h01);
        rd_chk(12'h010, 16'h0001, "R2 rise sets bit0");
        set_live(0, 8'h00);
        rd_chk(12'h010, 16'h0000, "R2 fall ignored bit0");

        // R4: pulse on either-edge bit stays latched
        set_live(3, 8'h02);
        set_live(3, 8'h00);
        rd_chk(12'h310, 16'h0002, "R4 sticky after pulse");

        // R9/R6: mask, interrupt, status view
        wr_reg(12'h218, 16'h0005);
        rd_chk(12'h218, 16'h0005, "R9 mask readback");
        set_live(2, 8'h04);
        chk_irq(8'h04, "R9 irq from masked flag");
        set_live(2, 8'h0C);
        rd_chk(12'h214, 16'h0004, "R6 istat masked view");
        rd_chk(12'h210, 16'h0000, "R6 istat read cleared all");
        chk_irq(8'h00, "R6 irq dropped");

        // R7: edge together with clearing read
        set_live(4, 8'h01);
        rd_live(12'h410, 16'h0001, "R7 read returns old flags", 4, 8'h05);
        rd_chk(12'h410, 16'h0004, "R7 same-cycle edge kept");

        // R1: channels 8..15 are dead, no aliasing
        set_live(1, 8'h02);
        rd_chk(12'h910, 16'h0000, "R1 channel 9 reads zero");
        rd_chk(12'h110, 16'h0002, "R1 channel 1 not cleared by alias");
        wr_reg(12'h918, 16'h00FF);
        rd_chk(12'h118, 16'h0000, "R1 alias write ignored");
        chk_irq(8'h00, "R1 irq unaffected");

        // R10: unknown offset
        set_live(5, 8'h02);
        rd_chk(12'h520, 16'h0000, "R10 unknown offset zero");
        rd_chk(12'h510, 16'h0002, "R10 flags kept");

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule